// File: doc/BRIEF.md
# Block Data Path Sequencer

This block moves 32-bit words between a host-side word FIFO and an abstracted card-side word stream for a single data transfer. Software writes a byte length, a timeout in card clock cycles, and a control word. The control word starts the transfer, selects its direction and gives the block size as a power-of-two exponent. The card side presents one word slot per `crd_strobe` pulse and one CRC verdict at the end of each block. Serial shifting and CRC arithmetic stay outside the block.

While a transfer runs, the sequencer counts the bytes left in the current block and in the whole transfer. It reports the FIFO fill level and the words still owed to the card, and it drives FIFO threshold flags for a polling or interrupt host. Each completed block raises a one-cycle block-end pulse and the final block also raises data-end. Four error conditions end a transfer early, each with its own one-cycle pulse: timeout, CRC failure, transmit underrun and receive overrun. After data-end or any error the sequencer returns to idle on its own. A control write with the start bit clear aborts the transfer at once.

Top module: `blkdp_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `tx_active` and `rx_active` are 0, `fifo_cnt` and `words_left` are 0, and every event and error output is 0.
- R2: A control write decodes bit 0 as start, bit 1 as direction (1 = card to host) and bits 7:4 as log2 of the block size in bytes, with values above 11 treated as 11 (2048 bytes). A write with bit 0 set and a nonzero length makes `busy` high in the next cycle. While busy, `tx_active` equals direction 0 and `rx_active` equals direction 1.
- R3: Each accepted card word moves min(4, bytes left in block, bytes left in transfer) bytes. When the block or the transfer runs out, the block waits for a CRC verdict. A passing verdict pulses `evt_blk_end` for one cycle, and this also applies to a short final block.
- R4: The passing verdict of the final block also pulses `evt_data_end` and clears `busy`. The FIFO contents are kept so that received words can still be popped while idle.
- R5: With direction 0, `tx_half_empty` is high when at least 8 of the 16 FIFO entries are free. With direction 1, `rx_half_full` is high when at least 8 words are held and `rx_avail` is high when at least 1 word is held. `fifo_cnt` gives the number of words held.
- R6: `words_left` equals the bytes still to be transferred, divided by 4 and rounded up.
- R7: While busy, if no card event arrives (a strobe while moving words, a CRC verdict while waiting) for more than the programmed timeout T cycles, `err_tmo` pulses in the (T+1)th cycle after the last event and the block goes idle.
- R8: A failing CRC verdict pulses `err_crc`, gives no block-end, and the block goes idle.
- R9: A card strobe during a host-to-card transfer with an empty FIFO pulses `err_underrun` and the block goes idle.
- R10: A card strobe during a card-to-host transfer with a full FIFO drops the word, pulses `err_overrun`, and the block goes idle with the FIFO still full.
- R11: A control write with bit 0 clear stops the transfer, makes `busy` low and empties the FIFO. Every control write empties the FIFO.
- R12: Host pushes have no effect while idle or during a card-to-host transfer, and no effect when the FIFO is full.
- R13: Starting with a zero length pulses `evt_data_end` in the next cycle and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_len | input | 1 | Load `cfg_len` into the length register |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_wr_tmo | input | 1 | Load `cfg_tmo` into the timeout register |
| cfg_tmo | input | TMO_W | Timeout in clock cycles |
| cfg_wr_ctl | input | 1 | Control write strobe |
| cfg_ctl | input | 8 | Control word: start, direction, block-size exponent |
| host_push | input | 1 | Host writes a word into the FIFO |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host removes the head word |
| host_rdata | output | 32 | FIFO head word for the host |
| crd_strobe | input | 1 | Card-side word slot this cycle |
| crd_rx_data | input | 32 | Word arriving from the card |
| crd_tx_data | output | 32 | Word offered to the card (FIFO head) |
| crc_valid | input | 1 | Block CRC verdict present |
| crc_ok | input | 1 | Verdict: 1 = CRC matched |
| busy | output | 1 | Transfer running (start bit readback) |
| tx_active | output | 1 | Busy, host to card |
| rx_active | output | 1 | Busy, card to host |
| fifo_cnt | output | $clog2(FIFO_DEPTH)+1 | Words held in the FIFO |
| words_left | output | LEN_W | Words still to transfer |
| tx_half_empty | output | 1 | Transmit threshold flag |
| rx_half_full | output | 1 | Receive threshold flag |
| rx_avail | output | 1 | Receive data present |
| evt_blk_end | output | 1 | One-cycle block completion pulse |
| evt_data_end | output | 1 | One-cycle transfer completion pulse |
| err_tmo | output | 1 | Timeout error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_underrun | output | 1 | Transmit underrun pulse |
| err_overrun | output | 1 | Receive overrun pulse |

## Verification
The counting logic is run in both directions with lengths that are not multiples of four or of the block size, so that a short last word and a short last block occur. These runs separate correct per-step byte arithmetic from plain word counting. Random block exponents from 0 to 6 cover blocks smaller than a word. A directed 2100-byte run with exponent 15 checks the clamp to 2048, because a missing clamp would end the first block at a different word. Directed fill, drain, starve, silence and bad-CRC sequences check each threshold, each error path and the exact cycle in which a timeout fires.

// File: rtl/blkdp_pkg.sv
// Shared constants, types and helpers for the block data path sequencer.
package blkdp_pkg;
    // Control word bit positions (behavioural: software encodes against them).
    localparam int CTL_START_BIT = 0;
    localparam int CTL_DIR_BIT   = 1;
    localparam int CTL_BSZ_LSB   = 4;
    localparam int CTL_BSZ_W     = 4;
    // Largest block exponent (2048 bytes) and width of the in-block counter.
    localparam int BSZ_MAX_LOG2  = 11;
    localparam int BLK_W         = BSZ_MAX_LOG2 + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CRC  = 2'd2
    } seq_state_e;

    // Limit a block exponent to the largest legal block size.
    function automatic logic [CTL_BSZ_W-1:0] clamp_bsz(input logic [CTL_BSZ_W-1:0] f);
        return (f > CTL_BSZ_W'(BSZ_MAX_LOG2)) ? CTL_BSZ_W'(BSZ_MAX_LOG2) : f;
    endfunction
endpackage

// File: rtl/blkdp_fifo.sv
// Word FIFO between host and card sides.
// Assumes DEPTH is a power of two; pushes when full and pops when empty are dropped.
module blkdp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    // R5
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/blkdp_xfer_cnt.sv
// Byte counters for the whole transfer and the current block.
// Assumes step is raised only while bytes remain and never together with load.
module blkdp_xfer_cnt
    import blkdp_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [LEN_W-1:0]     len,
    input  logic [CTL_BSZ_W-1:0] bsz_log2,
    input  logic                 step,
    input  logic                 blk_reload,
    output logic [LEN_W-1:0]     rem,
    output logic                 blk_last,
    output logic [LEN_W-1:0]     words_left
);
    logic [BLK_W-1:0] blk_rem;
    logic [2:0]       stp;
    logic [LEN_W:0]   rounded;

    // Bytes moved by one card word.
    always_comb begin
        stp = 3'd4;
        if (blk_rem < BLK_W'(4)) stp = blk_rem[2:0];
        if (rem < LEN_W'(stp))   stp = rem[2:0];
    end

    assign blk_last   = (blk_rem <= BLK_W'(4)) || (rem <= LEN_W'(4));
    assign rounded    = {1'b0, rem} + (LEN_W+1)'(3);
    assign words_left = LEN_W'(rounded >> 2);

    // Counter update on start, word step or next block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            blk_rem <= '0;
        end else if (load) begin
            rem     <= len;
            blk_rem <= BLK_W'(1) << bsz_log2;
        end else if (step) begin
            rem     <= rem - LEN_W'(stp);
            blk_rem <= blk_rem - BLK_W'(stp);
        end else if (blk_reload) begin
            blk_rem <= BLK_W'(1) << bsz_log2;
        end
    end

    // R3
    rem_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (rem < $past(rem)));
endmodule

// File: rtl/blkdp_timer.sv
// Inactivity down-counter; expired is high while running at zero count.
module blkdp_timer #(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    assign expired = run && (cnt == '0);

    // Reload on activity, otherwise count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/blkdp_engine.sv
// Block data path sequencer: runs one transfer between the word FIFO and the card
// word stream, with per-block CRC handshake, threshold flags and error detection.
// Assumes the card side strobes at most one word per cycle and gives one CRC
// verdict per block, only after the last word of that block.
module blkdp_engine
    import blkdp_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int TMO_W      = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int WORD_W    = 32,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1,
    localparam int HALF      = FIFO_DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_len,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_wr_tmo,
    input  logic [TMO_W-1:0]  cfg_tmo,
    input  logic              cfg_wr_ctl,
    input  logic [7:0]        cfg_ctl,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              crd_strobe,
    input  logic [WORD_W-1:0] crd_rx_data,
    output logic [WORD_W-1:0] crd_tx_data,
    input  logic              crc_valid,
    input  logic              crc_ok,
    output logic              busy,
    output logic              tx_active,
    output logic              rx_active,
    output logic [$clog2(FIFO_DEPTH):0] fifo_cnt,
    output logic [LEN_W-1:0]  words_left,
    output logic              tx_half_empty,
    output logic              rx_half_full,
    output logic              rx_avail,
    output logic              evt_blk_end,
    output logic              evt_data_end,
    output logic              err_tmo,
    output logic              err_crc,
    output logic              err_underrun,
    output logic              err_overrun
);
    seq_state_e           state;
    logic [LEN_W-1:0]     len_q;
    logic [TMO_W-1:0]     tmo_q;
    logic                 dir_q;
    logic [CTL_BSZ_W-1:0] bsz_q, bsz_new, bsz_sel;
    logic                 start, f_full, f_empty, f_push, f_pop;
    logic                 starve, flood, accept, crc_pass_more, tmr_load, tmr_exp;
    logic                 blk_last;
    logic [LEN_W-1:0]     rem;
    logic [WORD_W-1:0]    f_head;

    assign bsz_new  = clamp_bsz(cfg_ctl[CTL_BSZ_LSB +: CTL_BSZ_W]);
    assign bsz_sel  = cfg_wr_ctl ? bsz_new : bsz_q;
    assign start    = cfg_wr_ctl && cfg_ctl[CTL_START_BIT];

    // Card word classification in the word-moving state.
    assign starve   = !cfg_wr_ctl && state == ST_XFER && crd_strobe && !dir_q && f_empty;
    assign flood    = !cfg_wr_ctl && state == ST_XFER && crd_strobe && dir_q && f_full;
    assign accept   = !cfg_wr_ctl && state == ST_XFER && crd_strobe && !starve && !flood;
    assign crc_pass_more = !cfg_wr_ctl && state == ST_CRC && crc_valid && crc_ok && rem != '0;
    assign tmr_load = cfg_wr_ctl || (state == ST_XFER && crd_strobe)
                    || (state == ST_CRC && crc_valid);

    assign f_push = dir_q ? accept : (busy && host_push);
    assign f_pop  = dir_q ? host_pop : accept;

    assign busy          = (state != ST_IDLE);
    assign tx_active     = busy && !dir_q;
    assign rx_active     = busy && dir_q;
    assign host_rdata    = f_head;
    assign crd_tx_data   = f_head;
    assign tx_half_empty = !dir_q && ((CW'(FIFO_DEPTH) - fifo_cnt) >= CW'(HALF));
    assign rx_half_full  = dir_q && (fifo_cnt >= CW'(HALF));
    assign rx_avail      = dir_q && (fifo_cnt != '0);

    blkdp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(cfg_wr_ctl), .push(f_push),
        .wdata(dir_q ? crd_rx_data : host_wdata), .pop(f_pop), .rdata(f_head),
        .count(fifo_cnt), .full(f_full), .empty(f_empty)
    );

    blkdp_xfer_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(start), .len(len_q), .bsz_log2(bsz_sel),
        .step(accept), .blk_reload(crc_pass_more), .rem(rem), .blk_last(blk_last),
        .words_left(words_left)
    );

    blkdp_timer #(.TMO_W(TMO_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmo_q),
        .run(busy), .expired(tmr_exp)
    );

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            tmo_q <= '0;
            dir_q <= 1'b0;
            bsz_q <= '0;
        end else begin
            if (cfg_wr_len) len_q <= cfg_len;
            if (cfg_wr_tmo) tmo_q <= cfg_tmo;
            if (cfg_wr_ctl) begin
                dir_q <= cfg_ctl[CTL_DIR_BIT];
                bsz_q <= bsz_new;
            end
        end
    end

    // Sequencer state and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            evt_blk_end  <= 1'b0;
            evt_data_end <= 1'b0;
            err_tmo      <= 1'b0;
            err_crc      <= 1'b0;
            err_underrun <= 1'b0;
            err_overrun  <= 1'b0;
        end else begin
            evt_blk_end  <= 1'b0;
            evt_data_end <= 1'b0;
            err_tmo      <= 1'b0;
            err_crc      <= 1'b0;
            err_underrun <= 1'b0;
            err_overrun  <= 1'b0;
            if (cfg_wr_ctl) begin
                if (start && len_q == '0) begin
                    evt_data_end <= 1'b1;
                    state        <= ST_IDLE;
                end else begin
                    state <= start ? ST_XFER : ST_IDLE;
                end
            end else begin
                case (state)
                    ST_XFER: begin
                        if (starve) begin
                            err_underrun <= 1'b1;
                            state        <= ST_IDLE;
                        end else if (flood) begin
                            err_overrun <= 1'b1;
                            state       <= ST_IDLE;
                        end else if (accept) begin
                            if (blk_last) state <= ST_CRC;
                        end else if (tmr_exp) begin
                            err_tmo <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    ST_CRC: begin
                        if (crc_valid) begin
                            if (!crc_ok) begin
                                err_crc <= 1'b1;
                                state   <= ST_IDLE;
                            end else begin
                                evt_blk_end <= 1'b1;
                                if (rem == '0) begin
                                    evt_data_end <= 1'b1;
                                    state        <= ST_IDLE;
                                end else begin
                                    state <= ST_XFER;
                                end
                            end
                        end else if (tmr_exp) begin
                            err_tmo <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_q != '0) |=> busy);
    // R7
    tmo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> $past(tmr_exp));
    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> $past(crd_strobe && !dir_q));
    // R4 R8
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_tmo, err_crc, err_underrun, err_overrun, evt_data_end}));
    // R5
    dir_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_half_empty && (rx_avail || rx_half_full)));
endmodule

// File: tb/blkdp_engine_tb_top.sv
module blkdp_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int TMO_W = 32;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_len = 0, cfg_wr_tmo = 0, cfg_wr_ctl = 0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [TMO_W-1:0] cfg_tmo = '0;
    logic [7:0] cfg_ctl = '0;
    logic host_push = 0, host_pop = 0, crd_strobe = 0, crc_valid = 0, crc_ok = 0;
    logic [31:0] host_wdata = '0, crd_rx_data = '0;
    logic [31:0] host_rdata, crd_tx_data;
    logic busy, tx_active, rx_active, tx_half_empty, rx_half_full, rx_avail;
    logic evt_blk_end, evt_data_end, err_tmo, err_crc, err_underrun, err_overrun;
    logic [$clog2(DEPTH):0] fifo_cnt;
    logic [LEN_W-1:0] words_left;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkdp_engine #(.LEN_W(LEN_W), .TMO_W(TMO_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_len(cfg_wr_len), .cfg_len(cfg_len),
        .cfg_wr_tmo(cfg_wr_tmo), .cfg_tmo(cfg_tmo), .cfg_wr_ctl(cfg_wr_ctl),
        .cfg_ctl(cfg_ctl), .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata), .crd_strobe(crd_strobe),
        .crd_rx_data(crd_rx_data), .crd_tx_data(crd_tx_data), .crc_valid(crc_valid),
        .crc_ok(crc_ok), .busy(busy), .tx_active(tx_active), .rx_active(rx_active),
        .fifo_cnt(fifo_cnt), .words_left(words_left), .tx_half_empty(tx_half_empty),
        .rx_half_full(rx_half_full), .rx_avail(rx_avail), .evt_blk_end(evt_blk_end),
        .evt_data_end(evt_data_end), .err_tmo(err_tmo), .err_crc(err_crc),
        .err_underrun(err_underrun), .err_overrun(err_overrun)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int blk_bytes(int f);
        return 1 << ((f > 11) ? 11 : f);
    endfunction

    function automatic int exp_words(int bytes);
        return (bytes + 3) / 4;
    endfunction

    task automatic set_len(int l);
        cfg_len = LEN_W'(l); cfg_wr_len = 1; tick(); cfg_wr_len = 0;
    endtask

    task automatic set_tmo(int t);
        cfg_tmo = TMO_W'(t); cfg_wr_tmo = 1; tick(); cfg_wr_tmo = 0;
    endtask

    task automatic ctl(bit en, bit dir, int f);
        cfg_ctl = {4'(f), 2'b00, dir, en}; cfg_wr_ctl = 1; tick(); cfg_wr_ctl = 0;
    endtask

    task automatic push(logic [31:0] w);
        host_wdata = w; host_push = 1; tick(); host_push = 0;
    endtask

    task automatic pop();
        host_pop = 1; tick(); host_pop = 0;
    endtask

    task automatic strobe(logic [31:0] w);
        crd_rx_data = w; crd_strobe = 1; tick(); crd_strobe = 0;
    endtask

    task automatic crc(bit ok);
        crc_ok = ok; crc_valid = 1; tick(); crc_valid = 0;
    endtask

    // One complete transfer checked against bench byte arithmetic (R2 R3 R4 R6).
    task automatic run_xfer(bit dir, int len, int f);
        int rem = len;
        int bsz = blk_bytes(f);
        set_len(len);
        ctl(1, dir, f);
        chk("R2", "busy after start", busy, 1);
        chk("R2", "tx_active", tx_active, !dir);
        chk("R2", "rx_active", rx_active, dir);
        while (rem > 0) begin
            int bl = (rem < bsz) ? rem : bsz;
            int bleft = bl;
            while (bleft > 0) begin
                logic [31:0] w = $urandom;
                int s = (bleft < 4) ? bleft : 4;
                chk("R6", "words_left", words_left, exp_words(rem));
                if (!dir) begin
                    push(w);
                    chk("R3", "card tx word", crd_tx_data, w);
                    strobe(32'h0);
                end else begin
                    strobe(w);
                    chk("R3", "host rx word", host_rdata, w);
                    pop();
                end
                bleft -= s;
                rem -= s;
            end
            chk("R3", "no block end before crc", evt_blk_end, 0);
            crc(1);
            chk("R3", "block end", evt_blk_end, 1);
            chk("R4", "data end", evt_data_end, rem == 0);
            chk("R4", "busy after block", busy, rem != 0);
        end
        chk("R6", "words_left at end", words_left, 0);
        chk("R4", "fifo empty at end", fifo_cnt, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "tx_active", tx_active, 0);
        chk("R1", "rx_active", rx_active, 0);
        chk("R1", "fifo_cnt", fifo_cnt, 0);
        chk("R1", "words_left", words_left, 0);
        chk("R1", "events", {evt_blk_end, evt_data_end, err_tmo, err_crc,
                             err_underrun, err_overrun}, 0);

        set_tmo(1000);

        // Directed: short last word and short last block (R3 R4 R6)
        run_xfer(0, 10, 2);
        run_xfer(1, 13, 3);
        run_xfer(1, 3, 0);

        // R2 exponent 15 clamps to 2048-byte blocks
        run_xfer(0, 2100, 15);

        // Random transfers
        for (int i = 0; i < 24; i++) begin
            run_xfer(1'($urandom_range(0, 1)), $urandom_range(1, 80), $urandom_range(0, 6));
        end

        // R13 zero length
        set_len(0);
        ctl(1, 0, 2);
        chk("R13", "data end on zero length", evt_data_end, 1);
        chk("R13", "idle on zero length", busy, 0);

        // R5 transmit threshold and R12 full push ignored
        set_len(200);
        ctl(1, 0, 7);
        chk("R5", "tx_half_empty with 16 free", tx_half_empty, 1);
        for (int i = 0; i < 8; i++) push(32'h100 + 32'(i));
        chk("R5", "tx_half_empty with 8 free", tx_half_empty, 1);
        push(32'h200);
        chk("R5", "tx_half_empty with 7 free", tx_half_empty, 0);
        chk("R5", "fifo_cnt 9", fifo_cnt, 9);
        for (int i = 0; i < 8; i++) push(32'h300);
        chk("R12", "push when full ignored", fifo_cnt, 16);
        // R11 stop
        ctl(0, 0, 0);
        chk("R11", "busy after stop", busy, 0);
        chk("R11", "fifo flushed on stop", fifo_cnt, 0);
        push(32'h55);
        chk("R12", "push while idle ignored", fifo_cnt, 0);
        set_len(64);
        ctl(1, 1, 4);
        push(32'h66);
        chk("R12", "push during rx ignored", fifo_cnt, 0);

        // R5 receive thresholds and R10 overrun
        set_len(200);
        ctl(1, 1, 7);
        chk("R5", "rx_avail when empty", rx_avail, 0);
        for (int i = 0; i < 7; i++) strobe(32'(i));
        chk("R5", "rx_avail with 7", rx_avail, 1);
        chk("R5", "rx_half_full with 7", rx_half_full, 0);
        strobe(32'h7);
        chk("R5", "rx_half_full with 8", rx_half_full, 1);
        for (int i = 8; i < 16; i++) strobe(32'(i));
        chk("R5", "fifo_cnt full", fifo_cnt, 16);
        strobe(32'hdead);
        chk("R10", "overrun flagged", err_overrun, 1);
        chk("R10", "idle after overrun", busy, 0);
        chk("R10", "word dropped", fifo_cnt, 16);
        chk("R4", "head kept after stop", host_rdata, 0);
        pop();
        chk("R4", "pop while idle", fifo_cnt, 15);
        chk("R4", "next head", host_rdata, 1);

        // R9 underrun
        set_len(8);
        ctl(1, 0, 2);
        strobe(32'h0);
        chk("R9", "underrun flagged", err_underrun, 1);
        chk("R9", "idle after underrun", busy, 0);

        // R7 timeout exact cycle
        set_tmo(5);
        set_len(16);
        ctl(1, 1, 4);
        repeat (5) tick();
        chk("R7", "no timeout after 5 quiet cycles", err_tmo, 0);
        chk("R7", "still busy", busy, 1);
        tick();
        chk("R7", "timeout on 6th quiet cycle", err_tmo, 1);
        chk("R7", "idle after timeout", busy, 0);
        set_tmo(1000);

        // R8 CRC failure
        set_len(8);
        ctl(1, 1, 2);
        strobe(32'habc);
        crc(0);
        chk("R8", "crc error", err_crc, 1);
        chk("R8", "no block end on crc fail", evt_blk_end, 0);
        chk("R8", "idle after crc fail", busy, 0);

        // R11 control write flushes held data
        ctl(0, 1, 0);
        chk("R11", "flush on control write", fifo_cnt, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule